// File: doc/BRIEF.md
# CPU Bus Front-End Sequencer

This block sits between a 6502-class processor core and the rest of the system bus. It decides on which clock cycles the core may step. It runs the start-up sequence that fetches the reset vector, and it conditions the core's interrupt inputs. The core is outside the block. It sees only a step enable, a ready line, a program-counter load, and the interrupt requests.

After a synchronous reset, a down-counter holds the core idle for a fixed number of clocks. While it counts, the block puts the two reset-vector addresses on the memory bus in turn. It captures the returned bytes and pulses a load of the program counter with the assembled 16-bit value. From then on, the core steps on every cycle in which the video chip leaves the bus to the processor (aec high). The ready line copies the video chip's bus-available signal.

The maskable interrupt is treated as a level. The non-maskable interrupt is turned into a pending request on a high-to-low transition. The block samples both pins only on cycles where the core may step.

Top module: `cpufe_top`

## Requirements
- R1: While rst is high at a clock edge, the following hold after that edge: step_en=0, pc_load=0, irq_req=0, nmi_req=0 and mem_addr=0xFFFF.
- R2: The edges after rst is released are numbered 1, 2, and so on. mem_addr is 0xFFFC after edge 4 and 0xFFFD after edge 5, and 0xFFFF in every other cycle of the sequence. The byte on mem_rdata while 0xFFFC is shown is taken as the low vector byte, and the byte while 0xFFFD is shown as the high byte.
- R3: pc_load is high for exactly the one cycle after edge 6, and pc_value then equals {high byte, low byte}. pc_value keeps that value afterwards.
- R4: step_en is high exactly when the start-up count has finished (after edge 6), aec is high and rst is low. Before edge 6 it is low whatever aec is.
- R5: rdy equals ba combinationally, in every cycle.
- R6: On an edge where step_en is high, irq_req takes the inverse of irq_n. On any other edge irq_req keeps its value.
- R7: nmi_req is set when nmi_n was 1 at the previous stepping sample and is 0 at the current one. A low level that is held does not set it again.
- R8: Edges where step_en is low neither sample nmi_n nor update the remembered previous value. A low pulse that lies entirely inside a non-stepping gap is ignored. A pin that went low during a gap is detected at the first stepping sample.
- R9: nmi_req stays high until an edge with nmi_ack=1, which clears it even when not stepping. A new falling edge on the same edge as nmi_ack leaves nmi_req set.
- R10: Asserting rst in the middle of operation clears pending requests and restarts the whole vector fetch, so a new vector is loaded six edges after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aec | input | 1 | Bus granted to processor when high |
| ba | input | 1 | Bus-available signal from the video chip |
| irq_n | input | 1 | Maskable interrupt pin, active low |
| nmi_n | input | 1 | Non-maskable interrupt pin, active low |
| nmi_ack | input | 1 | One-cycle acknowledge of the pending NMI from the core |
| mem_rdata | input | 8 | Read data from the memory bus |
| mem_addr | output | 16 | Address driven during the vector fetch, 0xFFFF otherwise |
| pc_load | output | 1 | One-cycle program-counter load strobe |
| pc_value | output | 16 | Reset vector assembled from the two fetched bytes |
| step_en | output | 1 | Core may execute one step this cycle |
| rdy | output | 1 | Ready input to the core |
| irq_req | output | 1 | Level interrupt request, active high |
| nmi_req | output | 1 | Pending non-maskable request, active high |

## Verification
A wrong start-up count shows within six clocks of reset release. The vector addresses or the pc_load pulse land on the wrong edge, or step_en opens early, so the bench tracks every one of those edges. A corrupted remembered NMI level cannot be seen until the next stepping sample. It then shows as a missing or extra nmi_req one cycle later. For that reason the bench sets up pin transitions inside and across aec-low gaps and checks the request right after each stepping edge. A faulty hold or acknowledge path shows as irq_req or nmi_req changing on a cycle where nothing should move them.

// File: rtl/cpufe_pkg.sv
package cpufe_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic vecLo;     // low vector byte address on the bus, capture at edge
    logic vecHi;     // high vector byte address on the bus, load PC at edge
    logic sampleEn;  // interrupt pins are sampled at this edge
  } seqStrobes_t;

endpackage

// File: rtl/cpufe_ctrl.sv
module cpufe_ctrl
  import cpufe_pkg::*;
#(
  parameter int RESET_DELAY = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        aec,
  output seqStrobes_t strobes,
  output logic        stepEn
);

  localparam int CNT_W = $clog2(RESET_DELAY + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RESET_DELAY);
  localparam logic [CNT_W-1:0] LO_AT    = CNT_W'(2);
  localparam logic [CNT_W-1:0] HI_AT    = CNT_W'(1);

  logic [CNT_W-1:0] delayCnt;
  logic             bootDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      delayCnt <= LOAD_VAL;
    end else if (delayCnt != '0) begin
      delayCnt <= delayCnt - 1'b1;
    end
  end

  always_comb begin
    bootDone         = (delayCnt == '0);
    stepEn           = bootDone && aec && !rst;
    strobes.vecLo    = !rst && (delayCnt == LO_AT);
    strobes.vecHi    = !rst && (delayCnt == HI_AT);
    strobes.sampleEn = stepEn;
  end

  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (delayCnt != '0) |=> (delayCnt == $past(delayCnt) - 1'b1));

  // R2
  vec_order_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.vecHi |-> $past(strobes.vecLo));

  // R4
  no_step_boot_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.vecLo || strobes.vecHi) |-> !stepEn);

endmodule

// File: rtl/cpufe_dp.sv
module cpufe_dp
  import cpufe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  seqStrobes_t           strobes,
  input  logic                  irqN,
  input  logic                  nmiN,
  input  logic                  nmiAck,
  input  logic [DATA_W-1:0]     memRdata,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic                  pcLoad,
  output logic [2*DATA_W-1:0]   pcValue,
  output logic                  irqReq,
  output logic                  nmiReq
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] IDLE_ADDR = '1;
  localparam logic [ADDR_W-1:0] LO_ADDR   = IDLE_ADDR - ADDR_W'(3);
  localparam logic [ADDR_W-1:0] HI_ADDR   = IDLE_ADDR - ADDR_W'(2);

  logic [DATA_W-1:0] loByte;
  logic              nmiPrev;
  logic              nmiEdge;

  always_comb begin
    if (strobes.vecLo)      memAddr = LO_ADDR;
    else if (strobes.vecHi) memAddr = HI_ADDR;
    else                    memAddr = IDLE_ADDR;
    nmiEdge = strobes.sampleEn && nmiPrev && !nmiN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loByte  <= '0;
      pcValue <= '0;
      pcLoad  <= 1'b0;
      irqReq  <= 1'b0;
      nmiPrev <= 1'b1;
      nmiReq  <= 1'b0;
    end else begin
      pcLoad <= strobes.vecHi;
      if (strobes.vecLo) loByte <= memRdata;
      if (strobes.vecHi) pcValue <= {memRdata, loByte};
      if (strobes.sampleEn) begin
        irqReq  <= !irqN;
        nmiPrev <= nmiN;
      end
      nmiReq <= (nmiReq && !nmiAck) || nmiEdge;
    end
  end

  // R3
  pc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pcLoad |=> !pcLoad);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.sampleEn |=> $stable(irqReq));

  // R7
  nmi_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nmiReq) |-> ($past(strobes.sampleEn) && !$past(nmiN)));

  // R9
  nmi_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (nmiReq && !nmiAck) |=> nmiReq);

endmodule

// File: rtl/cpufe_top.sv
module cpufe_top
  import cpufe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RESET_DELAY = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                aec,
  input  logic                ba,
  input  logic                irq_n,
  input  logic                nmi_n,
  input  logic                nmi_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic                pc_load,
  output logic [2*DATA_W-1:0] pc_value,
  output logic                step_en,
  output logic                rdy,
  output logic                irq_req,
  output logic                nmi_req
);

  seqStrobes_t seqStrobes;

  assign rdy = ba;

  cpufe_ctrl #(.RESET_DELAY(RESET_DELAY)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .aec     (aec),
    .strobes (seqStrobes),
    .stepEn  (step_en)
  );

  cpufe_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (seqStrobes),
    .irqN     (irq_n),
    .nmiN     (nmi_n),
    .nmiAck   (nmi_ack),
    .memRdata (mem_rdata),
    .memAddr  (mem_addr),
    .pcLoad   (pc_load),
    .pcValue  (pc_value),
    .irqReq   (irq_req),
    .nmiReq   (nmi_req)
  );

endmodule

// File: tb/cpufe_top_tb.sv
module cpufe_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        aec = 1'b1;
  logic        ba = 1'b1;
  logic        irq_n = 1'b1;
  logic        nmi_n = 1'b1;
  logic        nmi_ack = 1'b0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        pc_load;
  logic [15:0] pc_value;
  logic        step_en, rdy, irq_req, nmi_req;
  logic [7:0]  vecLo = 8'h34;
  logic [7:0]  vecHi = 8'h12;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  // Memory model: vector bytes at 0xFFFC / 0xFFFD, filler elsewhere
  always_comb begin
    if (mem_addr == 16'hFFFC)      mem_rdata = vecLo;
    else if (mem_addr == 16'hFFFD) mem_rdata = vecHi;
    else                           mem_rdata = 8'hEE;
  end

  cpufe_top u_dut (
    .clk(clk), .rst(rst), .aec(aec), .ba(ba), .irq_n(irq_n), .nmi_n(nmi_n),
    .nmi_ack(nmi_ack), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .pc_load(pc_load), .pc_value(pc_value), .step_en(step_en), .rdy(rdy),
    .irq_req(irq_req), .nmi_req(nmi_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Release reset and follow the start-up sequence edge by edge
  task automatic bootRun(input logic [15:0] expPc);
    @(negedge clk);
    rst = 1'b0;
    aec = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      #2 chk("R4 step_en before edge", step_en, (k >= 7));
      @(posedge clk);
      #1;
      chk("R2 mem_addr", mem_addr,
          (k == 4) ? 16'hFFFC : (k == 5) ? 16'hFFFD : 16'hFFFF);
      chk("R3 pc_load", pc_load, (k == 6));
      if (k == 6) chk("R3 pc_value", pc_value, expPc);
      @(negedge clk);
    end
    chk("R3 pc_value held", pc_value, expPc);
  endtask

  // {aec, ba, irq_n, nmi_n, nmi_ack, exp step_en, exp rdy, exp irq_req, exp nmi_req}
  localparam int NV = 18;
  localparam logic [8:0] VEC [NV] = '{
    9'b11110_1100,  // idle
    9'b10010_1010,  // R6 irq low sampled, R5 rdy follows ba
    9'b01110_0110,  // R6 not stepping: irq_req held
    9'b11100_1101,  // R7 falling edge
    9'b11100_1101,  // R7 held low
    9'b11101_1100,  // R9 ack clears
    9'b11100_1100,  // R7 low level does not retrigger
    9'b11110_1100,  // back high
    9'b01100_0100,  // R8 low inside gap
    9'b01110_0100,  // R8 high again inside gap
    9'b11110_1100,  // R8 pulse ignored
    9'b00100_0000,  // R8 goes low inside gap
    9'b11100_1101,  // R8 detected at first stepping sample
    9'b11111_1100,  // R9 ack
    9'b11101_1101,  // R9 new edge with ack: set wins
    9'b11000_1111,  // irq and nmi together
    9'b01111_0110,  // R9 ack clears while not stepping
    9'b11110_1100   // quiet
  };

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 step_en", step_en, 1'b0);
    chk("R1 mem_addr", mem_addr, 16'hFFFF);
    chk("R1 pc_load", pc_load, 1'b0);
    chk("R1 irq_req", irq_req, 1'b0);
    chk("R1 nmi_req", nmi_req, 1'b0);

    bootRun(16'h1234);

    for (int i = 0; i < NV; i++) begin
      {aec, ba, irq_n, nmi_n, nmi_ack} = VEC[i][8:4];
      #2;
      chk("R4 step_en", step_en, VEC[i][3]);
      chk("R5 rdy", rdy, VEC[i][2]);
      @(posedge clk);
      #1;
      chk("R6 irq_req", irq_req, VEC[i][1]);
      chk("R7 nmi_req", nmi_req, VEC[i][0]);
      @(negedge clk);
    end
    nmi_ack = 1'b0;

    // R10: create pending requests, then reset in mid-run
    irq_n = 1'b0;
    nmi_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R10 setup nmi", nmi_req, 1'b1);
    chk("R10 setup irq", irq_req, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    irq_n = 1'b1;
    nmi_n = 1'b1;
    vecLo = 8'hA5;
    vecHi = 8'h5A;
    @(posedge clk);
    #1;
    chk("R10 nmi cleared", nmi_req, 1'b0);
    chk("R10 irq cleared", irq_req, 1'b0);
    chk("R1 step_en under reset", step_en, 1'b0);
    chk("R1 addr under reset", mem_addr, 16'hFFFF);
    ba = 1'b0;
    #1 chk("R5 rdy during reset", rdy, 1'b0);
    ba = 1'b1;
    bootRun(16'h5AA5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule